// File: doc/BRIEF.md
# Scanline Palette Change List Engine

This block owns a sixteen-colour palette in which every entry is a full byte of colour, plus a small engine that changes entries at a chosen display line without CPU timing. Software places a list of (index, colour) pairs in memory. It then writes the list's start address, its entry count and the display line where the new colours must take effect into control registers, and arms the engine. The engine reads the list through a simple memory read port into an internal buffer. It then waits for the horizontal blanking interval of the line just before the target line. During that interval it copies the buffered entries into the palette, one per clock, so that the whole target line is drawn with the new colours.

The pixel path presents a 4-bit colour index every clock and gets the palette byte back one clock later. The CPU can also write and read palette entries directly through two banks of eight registers.

The engine is a five-state machine:
- `ST_IDLE`: waits for an arm command.
- `ST_FETCH_IDX`: reads the index byte of the current entry.
- `ST_FETCH_COL`: reads the colour byte and stores the pair in the buffer.
- `ST_WAIT_LINE`: waits for the trigger.
- `ST_APPLY`: writes one buffered entry per clock.

Its transitions are:
- arm (`ST_IDLE`→`ST_FETCH_IDX`, or →`ST_WAIT_LINE` for an empty list)
- index acknowledged (`ST_FETCH_IDX`→`ST_FETCH_COL`)
- colour acknowledged (back to `ST_FETCH_IDX`, or to `ST_WAIT_LINE` after the last entry)
- line trigger (`ST_WAIT_LINE`→`ST_APPLY`)
- last entry written (`ST_APPLY`→`ST_IDLE`)

Top module: `pal_list_engine`

## Requirements
- R1: The palette has 16 byte-wide entries, all zero after reset. A CPU write to register address 0x10+i (i = 0..7, low bank) or 0x18+(i-8) (i = 8..15, high bank) sets entry i. A read of that same address returns the entry combinationally.
- R2: `pix_color` equals the palette entry selected by `pix_idx` at the previous rising clock edge, using the palette contents before any write at that same edge.
- R3: The control registers are read/write:
  - 0x00: list address bits 7:0
  - 0x01: list address bits 15:8
  - 0x02: list length in entries
  - 0x03: target line bits 7:0
  - 0x04: target line bit 8, in bit 0

  Writing 0x05 with bit 0 set arms the engine. Arming captures the register values, so later writes to these registers do not affect the armed list.
- R4: Entry k is fetched in list order. Its index comes from address base+2k, where only the low 4 bits are used and the high nibble is ignored. Its colour comes from address base+2k+1. `mem_req` stays high with a stable `mem_addr` until `mem_ack`, and `mem_rdata` is taken in the acknowledge cycle.
- R5: A length above 16 is clamped to 16 entries, so only the first 16 entries are fetched and applied. In that case status bit 2 is set. It is cleared by the next arm with a length of 16 or less.
- R6: After the fetch completes, the trigger is the first clock where `hblank` is high and `line_num` equals target-1. The entries are written one per clock, starting on the following clock, in list order, so a later entry with the same index wins. The palette is unchanged before the trigger.
- R7: A target line of 0 triggers on line LINES-1.
- R8: Status reads at 0x06. Bit 0 (busy) is high from the arm until the last entry is written. Bit 1 (done) is set when the list has been applied and cleared by the next arm.
- R9: An arm command while busy is ignored, and the running list completes with its captured settings.
- R10: A length of 0 performs no memory read. The engine reports done at the trigger and leaves the palette unchanged.
- R11: After reset: status reads 0, `mem_req` is low and `pix_color` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_req | output | 1 | List fetch request |
| mem_addr | output | 16 | List fetch byte address |
| mem_ack | input | 1 | Fetch acknowledge, data valid |
| mem_rdata | input | 8 | Fetched byte |
| line_num | input | 9 | Current display line |
| hblank | input | 1 | Horizontal blanking active |
| pix_idx | input | 4 | Pixel colour index |
| pix_color | output | 8 | Palette colour for the index, one clock later |

## Verification
The list mechanism is exercised with four distinct lists:
- A short list holding a duplicated index and a non-zero high nibble. This distinguishes in-order application and nibble masking from reordering or full-byte decoding.
- An over-long list whose tail would overwrite earlier entries. This distinguishes real clamping from fetching past 16.
- A list targeting line 0. This exposes a wrong wrap of the line-before-target calculation.
- An empty list. This separates "done at trigger" from "stuck or fetching".

Acknowledge latency varies with the fetch address, so request holding is tested under both immediate and delayed replies. A pixel index sweeping every clock compares the lookup port against the model throughout each apply window.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int IDX_W    = 4;
    localparam int COL_W    = 8;
    localparam int ADDR_W   = 16;
    localparam int LEN_W    = 8;
    localparam int REG_AW   = 5;
    localparam int NUM_COLS = 1 << IDX_W;
    localparam int ENT_W    = IDX_W + COL_W;

    localparam logic [REG_AW-1:0] REG_BASE_LO = 5'h00;
    localparam logic [REG_AW-1:0] REG_BASE_HI = 5'h01;
    localparam logic [REG_AW-1:0] REG_LEN     = 5'h02;
    localparam logic [REG_AW-1:0] REG_TGT_LO  = 5'h03;
    localparam logic [REG_AW-1:0] REG_TGT_HI  = 5'h04;
    localparam logic [REG_AW-1:0] REG_CTRL    = 5'h05;
    localparam logic [REG_AW-1:0] REG_STAT    = 5'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_IDX,
        ST_FETCH_COL,
        ST_WAIT_LINE,
        ST_APPLY
    } eng_state_t;

endpackage

// File: rtl/pal_ram.sv
module pal_ram
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [COL_W-1:0] wdata,
    input  logic [IDX_W-1:0] cpu_raddr,
    output logic [COL_W-1:0] cpu_rdata,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [COL_W-1:0] pix_color
);

    logic [COL_W-1:0] mem_q [NUM_COLS];

    // Storage: one always_ff per entry keeps the reset explicit.
    for (genvar g = 0; g < NUM_COLS; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (we && waddr == IDX_W'(g))
                mem_q[g] <= wdata;
        end
    end

    // Registered lookup for the pixel path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pix_color <= '0;
        else
            pix_color <= mem_q[pix_idx];
    end

    // Combinational read for the CPU.
    assign cpu_rdata = mem_q[cpu_raddr];

endmodule

// File: rtl/pal_list_buf.sv
module pal_list_buf
    import pal_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [ENT_W-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [ENT_W-1:0]         rdata
);

    logic [ENT_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (we && waddr == ($clog2(DEPTH))'(g))
                slot_q[g] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];

endmodule

// File: rtl/pal_list_fsm.sv
module pal_list_fsm
    import pal_pkg::*;
#(
    parameter int MAX_ENTRIES = 16,
    parameter int LINE_W      = 9,
    parameter int LINES       = 312,
    parameter int PTR_W       = $clog2(MAX_ENTRIES),
    parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [LINE_W-1:0] cfg_tgt,
    input  logic [LINE_W-1:0] line_num,
    input  logic              hblank,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [COL_W-1:0]  mem_rdata,
    output logic              buf_we,
    output logic [PTR_W-1:0]  buf_ptr,
    output logic [ENT_W-1:0]  buf_wdata,
    output logic              list_we,
    output logic              busy,
    output logic              done,
    output logic              clamped,
    output logic [CNT_W-1:0]  ent_cnt
);

    eng_state_t        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LINE_W-1:0] tgt_q;
    logic              done_q;
    logic              clamp_q;

    logic              last_ent;
    logic              trig;
    logic [LINE_W-1:0] prev_line;
    logic              len_over;
    logic [CNT_W-1:0]  len_eff;

    assign last_ent  = (CNT_W'(ptr_q) + CNT_W'(1)) == cnt_q;
    assign prev_line = (tgt_q == '0) ? LINE_W'(LINES - 1) : tgt_q - LINE_W'(1);
    assign trig      = hblank && (line_num == prev_line);
    assign len_over  = cfg_len > LEN_W'(MAX_ENTRIES);
    assign len_eff   = len_over ? CNT_W'(MAX_ENTRIES) : CNT_W'(cfg_len);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (arm) state_d = (cfg_len == '0) ? ST_WAIT_LINE : ST_FETCH_IDX;
            ST_FETCH_IDX: if (mem_ack) state_d = ST_FETCH_COL;
            ST_FETCH_COL: if (mem_ack) state_d = last_ent ? ST_WAIT_LINE : ST_FETCH_IDX;
            ST_WAIT_LINE: if (trig) state_d = ST_APPLY;
            ST_APPLY:     if (cnt_q == '0 || last_ent) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        mem_req   = (state_q == ST_FETCH_IDX) || (state_q == ST_FETCH_COL);
        mem_addr  = base_q + ADDR_W'({ptr_q, state_q == ST_FETCH_COL});
        buf_we    = (state_q == ST_FETCH_COL) && mem_ack;
        buf_ptr   = ptr_q;
        buf_wdata = {idx_q, mem_rdata};
        list_we   = (state_q == ST_APPLY) && (cnt_q != '0);
        busy      = state_q != ST_IDLE;
        done      = done_q;
        clamped   = clamp_q;
        ent_cnt   = cnt_q;
    end

    // Working registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            cnt_q   <= '0;
            ptr_q   <= '0;
            idx_q   <= '0;
            tgt_q   <= '0;
            done_q  <= 1'b0;
            clamp_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (arm) begin
                        base_q  <= cfg_base;
                        tgt_q   <= cfg_tgt;
                        cnt_q   <= len_eff;
                        clamp_q <= len_over;
                        done_q  <= 1'b0;
                        ptr_q   <= '0;
                    end
                end
                ST_FETCH_IDX: begin
                    if (mem_ack)
                        idx_q <= mem_rdata[IDX_W-1:0];
                end
                ST_FETCH_COL: begin
                    if (mem_ack)
                        ptr_q <= last_ent ? '0 : ptr_q + PTR_W'(1);
                end
                ST_WAIT_LINE: begin
                    if (trig)
                        ptr_q <= '0;
                end
                ST_APPLY: begin
                    if (cnt_q == '0 || last_ent)
                        done_q <= 1'b1;
                    else
                        ptr_q <= ptr_q + PTR_W'(1);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pal_list_engine.sv
module pal_list_engine
    import pal_pkg::*;
#(
    parameter int MAX_ENTRIES = 16,
    parameter int LINE_W      = 9,
    parameter int LINES       = 312
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              mem_req,
    output logic [15:0]       mem_addr,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    input  logic [LINE_W-1:0] line_num,
    input  logic              hblank,
    input  logic [3:0]        pix_idx,
    output logic [7:0]        pix_color
);

    localparam int PTR_W = $clog2(MAX_ENTRIES);
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

    logic [ADDR_W-1:0] cfg_base;
    logic [LEN_W-1:0]  cfg_len;
    logic [LINE_W-1:0] cfg_tgt;
    logic              arm;
    logic              cpu_pal_we;
    logic              buf_we;
    logic [PTR_W-1:0]  buf_ptr;
    logic [ENT_W-1:0]  buf_wdata;
    logic [ENT_W-1:0]  buf_rdata;
    logic              list_we;
    logic              eng_busy;
    logic              eng_done;
    logic              eng_clamp;
    logic [CNT_W-1:0]  eng_cnt;
    logic              pal_we;
    logic [IDX_W-1:0]  pal_waddr;
    logic [COL_W-1:0]  pal_wdata;
    logic [COL_W-1:0]  cpu_pal_rdata;

    assign arm        = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[0];
    assign cpu_pal_we = reg_wr && reg_addr[4];

    // Configuration registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_base <= '0;
            cfg_len  <= '0;
            cfg_tgt  <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                REG_BASE_LO: cfg_base[7:0]        <= reg_wdata;
                REG_BASE_HI: cfg_base[15:8]       <= reg_wdata;
                REG_LEN:     cfg_len              <= reg_wdata;
                REG_TGT_LO:  cfg_tgt[7:0]         <= reg_wdata;
                REG_TGT_HI:  cfg_tgt[LINE_W-1:8]  <= reg_wdata[LINE_W-9:0];
                default: ;
            endcase
        end
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[4]) begin
            reg_rdata = cpu_pal_rdata;
        end else begin
            unique case (reg_addr)
                REG_BASE_LO: reg_rdata = cfg_base[7:0];
                REG_BASE_HI: reg_rdata = cfg_base[15:8];
                REG_LEN:     reg_rdata = cfg_len;
                REG_TGT_LO:  reg_rdata = cfg_tgt[7:0];
                REG_TGT_HI:  reg_rdata = 8'(cfg_tgt[LINE_W-1:8]);
                REG_STAT:    reg_rdata = {5'b0, eng_clamp, eng_done, eng_busy};
                default:     reg_rdata = '0;
            endcase
        end
    end

    // The list write has priority over a CPU write in the same cycle.
    assign pal_we    = list_we || cpu_pal_we;
    assign pal_waddr = list_we ? buf_rdata[ENT_W-1:COL_W] : reg_addr[IDX_W-1:0];
    assign pal_wdata = list_we ? buf_rdata[COL_W-1:0]     : reg_wdata;

    pal_list_fsm #(
        .MAX_ENTRIES (MAX_ENTRIES),
        .LINE_W      (LINE_W),
        .LINES       (LINES),
        .PTR_W       (PTR_W),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .cfg_base  (cfg_base),
        .cfg_len   (cfg_len),
        .cfg_tgt   (cfg_tgt),
        .line_num  (line_num),
        .hblank    (hblank),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .buf_we    (buf_we),
        .buf_ptr   (buf_ptr),
        .buf_wdata (buf_wdata),
        .list_we   (list_we),
        .busy      (eng_busy),
        .done      (eng_done),
        .clamped   (eng_clamp),
        .ent_cnt   (eng_cnt)
    );

    pal_list_buf #(
        .DEPTH (MAX_ENTRIES)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .waddr (buf_ptr),
        .wdata (buf_wdata),
        .raddr (buf_ptr),
        .rdata (buf_rdata)
    );

    pal_ram u_pal (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (pal_we),
        .waddr     (pal_waddr),
        .wdata     (pal_wdata),
        .cpu_raddr (reg_addr[IDX_W-1:0]),
        .cpu_rdata (cpu_pal_rdata),
        .pix_idx   (pix_idx),
        .pix_color (pix_color)
    );

endmodule

// File: rtl/pal_list_engine_chk.sv
module pal_list_engine_chk #(
    parameter int MAX_ENTRIES = 16,
    parameter int CNT_W       = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [15:0]      mem_addr,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] ent_cnt
);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R10
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R8
    arm_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done);

    // R5
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_cnt <= CNT_W'(MAX_ENTRIES));

endmodule

bind pal_list_engine pal_list_engine_chk #(
    .MAX_ENTRIES (MAX_ENTRIES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .busy     (eng_busy),
    .done     (eng_done),
    .ent_cnt  (eng_cnt)
);

// File: tb/pal_list_engine_tb.sv
module pal_list_engine_tb;

    localparam int LINES   = 312;
    localparam int LINE_CY = 40;
    localparam int HB_FROM = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       mem_req;
    logic [15:0] mem_addr;
    logic       mem_ack = 1'b0;
    logic [7:0] mem_rdata = '0;
    logic [8:0] line_num = '0;
    logic       hblank = 1'b0;
    logic [3:0] pix_idx = '0;
    logic [7:0] pix_color;

    int checks = 0;
    int fails  = 0;
    int hc     = 0;
    int cyc    = 0;
    int wc     = 0;
    logic [7:0] mem [256];

    always #10 clk = ~clk;

    pal_list_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .line_num(line_num), .hblank(hblank), .pix_idx(pix_idx),
        .pix_color(pix_color)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Line timing, pixel index sweep and memory responder, 3 ns after each edge.
    always @(posedge clk) begin
        #3;
        cyc++;
        pix_idx = cyc[3:0];
        if (rst_n) begin
            if (hc == LINE_CY - 1) begin
                hc = 0;
                line_num = (line_num == 9'(LINES - 1)) ? '0 : line_num + 9'd1;
            end else begin
                hc++;
            end
        end
        hblank = hc >= HB_FROM;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wc >= int'(mem_addr[1])) begin
                mem_ack   = 1'b1;
                mem_rdata = mem[mem_addr[7:0]];
                wc        = 0;
            end else begin
                wc++;
            end
        end
    end

    // Behavioural reference model.
    int mpal [16];
    int mst, mbase, mcnt, mtgt, mapp, midx, mpix;
    int cb, cl, ct;
    bit mdone, mclamp, mreq;
    int maddr;
    int mq [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mpal[i]) mpal[i] = 0;
            mst = 0; mbase = 0; mcnt = 0; mtgt = 0; mapp = 0; midx = 0; mpix = 0;
            cb = 0; cl = 0; ct = 0; mdone = 0; mclamp = 0;
            mq.delete();
        end else begin
            mpix = mpal[pix_idx];
            if (mst == 4 && mcnt != 0) begin
                mpal[mq[mapp] >> 8] = mq[mapp] & 255;
            end else if (reg_wr && reg_addr[4]) begin
                mpal[reg_addr[3:0]] = reg_wdata;
            end
            case (mst)
                0: if (reg_wr && reg_addr == 5'h05 && reg_wdata[0]) begin
                       mbase = cb; mtgt = ct;
                       mcnt = (cl > 16) ? 16 : cl;
                       mclamp = cl > 16; mdone = 0;
                       mq.delete();
                       mst = (cl == 0) ? 3 : 1;
                   end
                1: if (mem_ack) begin midx = mem_rdata & 15; mst = 2; end
                2: if (mem_ack) begin
                       mq.push_back(midx * 256 + mem_rdata);
                       if (mq.size() == mcnt) mst = 3; else mst = 1;
                   end
                3: if (hblank && int'(line_num) == ((mtgt == 0) ? LINES - 1 : mtgt - 1)) begin
                       mst = 4; mapp = 0;
                   end
                4: begin
                       mapp++;
                       if (mcnt == 0 || mapp == mcnt) begin mst = 0; mdone = 1; end
                   end
                default: mst = 0;
            endcase
            if (reg_wr) begin
                case (reg_addr)
                    5'h00: cb = (cb & 16'hFF00) | reg_wdata;
                    5'h01: cb = (cb & 16'h00FF) | (int'(reg_wdata) << 8);
                    5'h02: cl = reg_wdata;
                    5'h03: ct = (ct & 256) | reg_wdata;
                    5'h04: ct = (ct & 255) | (int'(reg_wdata[0]) << 8);
                    default: ;
                endcase
            end
        end
        mreq  = (mst == 1 || mst == 2);
        maddr = (mbase + 2 * mq.size() + ((mst == 2) ? 1 : 0)) & 16'hFFFF;
    end

    // Every-clock comparison on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(pix_color), mpix, "R2 pixel lookup");
            chk(int'(mem_req), int'(mreq), "R4 fetch request");
            if (mreq) chk(int'(mem_addr), maddr, "R4 fetch address");
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(posedge clk); #5;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #5;
        reg_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [4:0] a, input int exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        chk(int'(reg_rdata), exp, tag);
    endtask

    task automatic rd(input logic [4:0] a, input int exp, input string tag);
        @(posedge clk); #5;
        rd_now(a, exp, tag);
    endtask

    task automatic wait_at(input int l, input int h);
        do begin
            @(posedge clk); #5;
        end while (!(int'(line_num) == l && hc == h));
    endtask

    task automatic arm(input int base, input int len, input int tgt);
        wr(5'h00, 8'(base));
        wr(5'h01, 8'(base >> 8));
        wr(5'h02, 8'(len));
        wr(5'h03, 8'(tgt));
        wr(5'h04, 8'(tgt >> 8));
        wr(5'h05, 8'h01);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cyc == 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        foreach (mem[i]) mem[i] = 8'(i * 29 + 7);
        // short list: duplicate index 2, high nibble set on third index
        mem[8'h20] = 8'h02; mem[8'h21] = 8'hA2;
        mem[8'h22] = 8'h09; mem[8'h23] = 8'h99;
        mem[8'h24] = 8'hF2; mem[8'h25] = 8'h5B;
        // over-long list: 20 entries, index k, colour C0+k
        for (int k = 0; k < 20; k++) begin
            mem[8'h40 + 2 * k]     = 8'(8'hA0 | (k & 15));
            mem[8'h40 + 2 * k + 1] = 8'(8'hC0 + k);
        end
        mem[8'h80] = 8'h05; mem[8'h81] = 8'h55;

        repeat (4) @(posedge clk);
        #5;
        // R11 reset state
        rd_now(5'h06, 0, "R11 status after reset");
        chk(int'(mem_req), 0, "R11 no request after reset");
        chk(int'(pix_color), 0, "R11 pixel output after reset");
        rd_now(5'h15, 0, "R11 palette cleared");
        rst_n = 1'b1;

        // R1 direct palette writes through both banks
        for (int i = 0; i < 16; i++) wr(5'(5'h10 + i), 8'(8'h10 + i));
        rd(5'h13, 8'h13, "R1 low bank readback");
        rd(5'h1C, 8'h1C, "R1 high bank readback");

        // R6 short list, R4 masking, R9 ignored re-arm, R3 capture
        wait_at(3, 0);
        arm(16'h0020, 3, 10);
        rd(5'h00, 8'h20, "R3 base register readback");
        wr(5'h02, 8'h01);
        wr(5'h05, 8'h01);
        rd(5'h02, 8'h01, "R3 length register readback");
        wait_at(8, 0);
        rd_now(5'h06, 1, "R8 busy while waiting (R9 re-arm ignored)");
        wait_at(9, 19);
        rd_now(5'h12, 8'h12, "R6 palette unchanged before trigger");
        wait_at(10, 0);
        rd_now(5'h12, 8'h5B, "R6 later duplicate wins, R4 high nibble ignored");
        rd(5'h19, 8'h99, "R9 captured length still applied");
        rd(5'h06, 2, "R8 done after apply");

        // R5 clamp
        wait_at(20, 0);
        arm(16'h0040, 20, 100);
        wait_at(101, 0);
        rd_now(5'h10, 8'hC0, "R5 entries beyond 16 not applied");
        rd(5'h1F, 8'hCF, "R5 sixteenth entry applied");
        rd(5'h06, 6, "R5 clamp flag with done");

        // R7 target line 0
        wait_at(120, 0);
        arm(16'h0080, 1, 0);
        wait_at(LINES - 1, 19);
        rd_now(5'h15, 8'hC5, "R7 unchanged before last-line blanking");
        wait_at(0, 0);
        rd_now(5'h15, 8'h55, "R7 applied for line 0");
        rd(5'h06, 2, "R5 clamp cleared by short list");

        // R10 empty list
        wait_at(5, 0);
        arm(16'h0030, 0, 50);
        wait_at(30, 0);
        rd_now(5'h06, 1, "R10 busy without fetching");
        wait_at(51, 0);
        rd_now(5'h06, 2, "R10 done at trigger");
        rd(5'h17, 8'hC7, "R10 palette unchanged");

        repeat (5) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule